// File: doc/BRIEF.md
# Load-store unit with misaligned splitting

This block sits between a processor pipeline and its data memory. The pipeline presents one load or store at a time. Each command carries a byte address, an access size, write data and a flag that selects sign extension. The unit turns the command into word-aligned bus transactions on a request/grant/response bus. For loads it returns read data already shifted to bit 0 and extended. For every access it raises a one-cycle completion pulse with an error flag. While the command is still in flight it asks the pipeline to stall.

An access that crosses a 4-byte boundary is split into two transactions. The first goes to the lower word and the second to the next word. For loads, the two responses are merged into one result. If the lower part comes back with an error, the access is reported as failed at once. The upper part is still issued under the normal handshake, and its response is discarded. Until it drains, any new command waits.

The pipeline must keep a command and its fields stable while `stall_o` is high. It may present the next command in the cycle after `done_o`. Only one bus transaction is outstanding at a time.

Top module: `lsu_split`

## Requirements
- R1: Size code 0 moves a byte, code 1 a halfword and code 2 a word. Load results are zero-extended, or sign-extended when the signed flag is set.
- R2: The bus address always has bits [1:0] equal to zero. Byte enable bit k marks byte lane k, meaning data bits [8k+7:8k]. The enables cover exactly the bytes of the access that fall in the addressed word.
- R3: Store data is rotated left by 8 times the byte offset. Byte i of the command therefore lands on lane (offset+i) mod 4.
- R4: `bus_req_o` stays high until the cycle in which `bus_gnt_i` is high. Address, write enable, byte enables and write data keep their values until then. A grant may arrive in the request's own cycle.
- R5: `stall_o` is high whenever a command is presented and `done_o` is low. Completion comes at least one cycle after the command is first presented, for stores as well as loads.
- R6: A word access with a nonzero offset, or a halfword access at offset 3, becomes two transactions. The second goes to the word address plus 4, and is issued after the first response.
- R7: A split load assembles its result from the upper bytes of the first response and the lower bytes of the second.
- R8: An error on the first part of a split access ends the access at once, with `done_o` and `err_o` high. The second part is still requested, and its response produces no completion.
- R9: A command presented while an abandoned second part is outstanding issues no bus request of its own until that part has completed.
- R10: A response with its error flag set, on a single access or on the second part of a split, completes the access with `err_o` high, in the response cycle.
- R11: No new bus request is raised while a granted transaction awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A load/store command is presented |
| cmd_we_i | input | 1 | 1 for store, 0 for load |
| cmd_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| cmd_signed_i | input | 1 | Sign-extend the load result |
| cmd_addr_i | input | ADDR_W | Byte address |
| cmd_wdata_i | input | 32 | Store data, least significant bytes used |
| stall_o | output | 1 | Pipeline must hold the command |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion carries an error |
| rdata_o | output | 32 | Extended load result, valid with done_o |
| bus_req_o | output | 1 | Bus request valid |
| bus_gnt_i | input | 1 | Bus accepted the request |
| bus_addr_o | output | ADDR_W | Word-aligned bus address |
| bus_we_o | output | 1 | Bus write enable |
| bus_be_o | output | 4 | Bus byte enables |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rvalid_i | input | 1 | Response valid, one cycle |
| bus_err_i | input | 1 | Response error flag |
| bus_rdata_i | input | 32 | Response read data |

## Verification
The bench builds the unit with ADDR_W set to 16 and connects it to a 256-byte memory model with one faulting word. This makes every address the random traffic produces a real, checkable location. Accesses near the top of the space carry the second part past the model's end, where it wraps. The faulting word can land in the lower part, the upper part or a single access. The model also varies grant delay and response delay. As a result, both the held request and the merge of split-load data are exercised across timing variations.

// File: rtl/lsu_split.sv
module lsu_split #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_size_i,
  input  logic              cmd_signed_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [31:0]       cmd_wdata_i,
  output logic              stall_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_we_o,
  output logic [3:0]        bus_be_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_rvalid_i,
  input  logic              bus_err_i,
  input  logic [31:0]       bus_rdata_i
);

  typedef enum logic [1:0] {IDLE, WAIT1, REQ2, WAIT2} st_t;

  st_t               st_q;
  logic              we_q, sgn_q, split_q, abort_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q, lo_q;

  logic              idle;
  logic              cur_we;
  logic [1:0]        cur_size;
  logic [ADDR_W-1:0] cur_addr, base_addr;
  logic [31:0]       cur_wdata;
  logic [3:0]        mask4;
  logic [7:0]        mask8;
  logic [63:0]       rot, merged;
  logic [31:0]       raw;

  assign idle      = (st_q == IDLE);
  assign cur_we    = idle ? cmd_we_i     : we_q;
  assign cur_size  = idle ? cmd_size_i   : size_q;
  assign cur_addr  = idle ? cmd_addr_i   : addr_q;
  assign cur_wdata = idle ? cmd_wdata_i  : wdata_q;

  always_comb begin
    case (cur_size)
      2'd0:    mask4 = 4'b0001;
      2'd1:    mask4 = 4'b0011;
      default: mask4 = 4'b1111;
    endcase
  end

  assign mask8     = {4'b0000, mask4} << cur_addr[1:0];
  assign base_addr = {cur_addr[ADDR_W-1:2], 2'b00};
  assign rot       = {cur_wdata, cur_wdata} << {cur_addr[1:0], 3'b000};

  assign bus_req_o   = (idle && cmd_valid_i) || (st_q == REQ2);
  assign bus_addr_o  = (st_q == REQ2) ? base_addr + ADDR_W'(4) : base_addr;
  assign bus_be_o    = (st_q == REQ2) ? mask8[7:4] : mask8[3:0];
  assign bus_we_o    = cur_we;
  assign bus_wdata_o = rot[63:32];

  assign done_o  = bus_rvalid_i &&
                   (((st_q == WAIT1) && (!split_q || bus_err_i)) ||
                    ((st_q == WAIT2) && !abort_q));
  assign err_o   = done_o && bus_err_i;
  assign stall_o = cmd_valid_i && !done_o;

  assign merged = {bus_rdata_i, (st_q == WAIT2) ? lo_q : bus_rdata_i} >> {addr_q[1:0], 3'b000};
  assign raw    = merged[31:0];

  always_comb begin
    case (size_q)
      2'd0:    rdata_o = {{24{sgn_q & raw[7]}},  raw[7:0]};
      2'd1:    rdata_o = {{16{sgn_q & raw[15]}}, raw[15:0]};
      default: rdata_o = raw;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= IDLE;
      we_q    <= 1'b0;
      sgn_q   <= 1'b0;
      split_q <= 1'b0;
      abort_q <= 1'b0;
      size_q  <= 2'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      lo_q    <= '0;
    end else begin
      case (st_q)
        IDLE: if (cmd_valid_i) begin
          we_q    <= cmd_we_i;
          sgn_q   <= cmd_signed_i;
          size_q  <= cmd_size_i;
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_wdata_i;
          split_q <= |mask8[7:4];
          abort_q <= 1'b0;
          if (bus_gnt_i) st_q <= WAIT1;
        end
        WAIT1: if (bus_rvalid_i) begin
          lo_q <= bus_rdata_i;
          if (split_q) begin
            abort_q <= bus_err_i;
            st_q    <= REQ2;
          end else begin
            st_q <= IDLE;
          end
        end
        REQ2:  if (bus_gnt_i)    st_q <= WAIT2;
        WAIT2: if (bus_rvalid_i) st_q <= IDLE;
        default: st_q <= IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)
      && $stable(bus_we_o) && $stable(bus_wdata_o)); // R4
  AST_BE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_be_o != 4'b0000); // R2
  AST_DONE_ON_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bus_rvalid_i); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> !bus_req_o); // R11
  AST_SECOND_PART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WAIT1) && bus_rvalid_i && split_q |=> bus_req_o && (bus_be_o != 4'b0000)); // R6
  AST_ABANDON_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == REQ2) && abort_q && cmd_valid_i |-> stall_o); // R9

endmodule

// File: tb/lsu_split_tb_top.sv
`timescale 1ns/1ps
module lsu_split_tb_top;
  localparam int AW       = 16;
  localparam int ERR_WORD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 0, cmd_we = 0, cmd_signed = 0;
  logic [1:0]    cmd_size = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0]   cmd_wdata = '0;
  logic stall_o, done_o, err_o, bus_req_o, bus_we_o;
  logic [31:0]   rdata_o, bus_wdata_o;
  logic [AW-1:0] bus_addr_o;
  logic [3:0]    bus_be_o;
  logic gnt, rvalid = 0, rerr = 0;
  logic [31:0] rdat = '0;

  lsu_split #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_size_i(cmd_size),
    .cmd_signed_i(cmd_signed), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .stall_o(stall_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(gnt), .bus_addr_o(bus_addr_o),
    .bus_we_o(bus_we_o), .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o),
    .bus_rvalid_i(rvalid), .bus_err_i(rerr), .bus_rdata_i(rdat));

  function automatic logic [7:0] init_byte(int b);
    return 8'(b * 29 + 7);
  endfunction

  // memory model
  logic [31:0] mem [64];
  logic [7:0]  rng = 8'h5A;
  logic        pend = 0, pwe = 0;
  logic [1:0]  dly = 0;
  logic [5:0]  pidx = 0;
  assign gnt = bus_req_o && (rng[0] || rng[3]);

  always @(posedge clk) begin
    rng <= {rng[6:0], rng[7] ^ rng[5] ^ rng[4] ^ rng[3]};
    rvalid <= 1'b0;
    if (!rst_n) begin
      for (int w = 0; w < 64; w++)
        mem[w] <= {init_byte(4*w+3), init_byte(4*w+2), init_byte(4*w+1), init_byte(4*w)};
      pend <= 1'b0;
    end else begin
      if (pend) begin
        if (dly == 0) begin
          rvalid <= 1'b1;
          rerr   <= (pidx == 6'(ERR_WORD));
          rdat   <= pwe ? 32'h0 : mem[pidx];
          pend   <= 1'b0;
        end else dly <= dly - 2'd1;
      end
      if (bus_req_o && gnt) begin
        pend <= 1'b1;
        dly  <= {1'b0, rng[1]};
        pidx <= bus_addr_o[7:2];
        pwe  <= bus_we_o;
        if (bus_we_o && bus_addr_o[7:2] != 6'(ERR_WORD))
          for (int k = 0; k < 4; k++)
            if (bus_be_o[k]) mem[bus_addr_o[7:2]][8*k +: 8] <= bus_wdata_o[8*k +: 8];
      end
    end
  end

  // scoreboard
  typedef struct { logic we; logic err; logic [31:0] data; string tag; } exp_t;
  typedef struct { logic [AW-1:0] addr; logic [3:0] be; logic we; logic [31:0] wd; string tag; } bus_t;
  exp_t exp_q[$];
  bus_t bus_q[$];
  logic [7:0] ref_b [256];
  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  logic          prev_wait = 0, p_we = 0;
  logic [AW-1:0] p_addr = '0;
  logic [3:0]    p_be = '0;
  logic [31:0]   p_wd = '0;

  always @(negedge clk) if (rst_n) begin
    if (prev_wait)
      check(bus_req_o && bus_addr_o == p_addr && bus_be_o == p_be && bus_we_o == p_we && bus_wdata_o == p_wd,
            $sformatf("R4 request not held: addr %h be %b act, addr %h be %b exp", bus_addr_o, bus_be_o, p_addr, p_be));
    prev_wait = bus_req_o && !gnt;
    p_addr = bus_addr_o; p_be = bus_be_o; p_we = bus_we_o; p_wd = bus_wdata_o;
    if (bus_req_o && gnt) begin
      if (bus_q.size() == 0) check(0, "R11 unexpected bus grant: act 1 exp 0");
      else begin
        bus_t b;
        logic [31:0] m;
        b = bus_q.pop_front();
        m = {{8{b.be[3]}}, {8{b.be[2]}}, {8{b.be[1]}}, {8{b.be[0]}}};
        check(bus_addr_o == b.addr && bus_be_o == b.be && bus_we_o == b.we &&
              (!b.we || (bus_wdata_o & m) == (b.wd & m)),
              $sformatf("%s bus item: addr %h be %b we %b wd %h act, addr %h be %b we %b wd %h exp",
                        b.tag, bus_addr_o, bus_be_o, bus_we_o, bus_wdata_o, b.addr, b.be, b.we, b.wd));
      end
    end
    if (done_o) begin
      if (exp_q.size() == 0) check(0, "R8 completion without command: act 1 exp 0");
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(err_o == e.err && (e.we || e.err || rdata_o == e.data),
              $sformatf("%s result: err %b data %h act, err %b data %h exp", e.tag, err_o, rdata_o, e.err, e.data));
      end
    end
  end

  task automatic run_op(input bit we, input int size, input bit sgn, input int addr, input logic [31:0] wd);
    int off, n;
    logic [3:0] be1, be2;
    logic [31:0] lanes, raw, ext;
    logic [AW-1:0] a1, a2;
    bit split, e1, e2;
    exp_t e;
    bus_t b;
    off = addr & 3;
    n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    be1 = 0; be2 = 0; lanes = 0; raw = 0;
    for (int i = 0; i < n; i++) begin
      if (off + i < 4) be1[off+i] = 1'b1; else be2[off+i-4] = 1'b1;
      lanes[8*((off+i)%4) +: 8] = wd[8*i +: 8];
      raw[8*i +: 8] = ref_b[(addr + i) & 255];
    end
    split = (off + n) > 4;
    a1 = AW'(addr & ~3);
    a2 = a1 + AW'(4);
    e1 = ((addr >> 2) & 63) == ERR_WORD;
    e2 = split && (((addr >> 2) + 1) & 63) == ERR_WORD;
    if (size == 0)      ext = sgn ? {{24{raw[7]}}, raw[7:0]}   : {24'h0, raw[7:0]};
    else if (size == 1) ext = sgn ? {{16{raw[15]}}, raw[15:0]} : {16'h0, raw[15:0]};
    else                ext = raw;
    if (we)
      for (int i = 0; i < n; i++)
        if ((((addr + i) & 255) >> 2) != ERR_WORD) ref_b[(addr + i) & 255] = wd[8*i +: 8];
    e.we = we; e.err = e1 || e2; e.data = ext;
    e.tag = e1 ? (split ? "R8" : "R10") : e2 ? "R10" : split ? "R7" : "R1";
    exp_q.push_back(e);
    b.addr = a1; b.be = be1; b.we = we; b.wd = lanes; b.tag = we ? "R3" : "R2";
    bus_q.push_back(b);
    if (split) begin
      b.addr = a2; b.be = be2; b.tag = e1 ? "R9" : "R6";
      bus_q.push_back(b);
    end
    @(posedge clk); #1;
    cmd_valid = 1; cmd_we = we; cmd_size = 2'(size); cmd_signed = sgn;
    cmd_addr = AW'(addr); cmd_wdata = wd;
    #1;
    check(stall_o == 1'b1 && done_o == 1'b0,
          $sformatf("R5 stall on presentation: stall %b done %b act, 1 0 exp", stall_o, done_o));
    do @(negedge clk); while (!done_o);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired: act hung exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 256; b++) ref_b[b] = init_byte(b);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req_o && !done_o && !stall_o,
          $sformatf("R5 reset state: req %b done %b stall %b act, 0 0 0 exp", bus_req_o, done_o, stall_o));
    run_op(0, 2, 0, 'h10, 0);                // R1 aligned word
    run_op(0, 0, 1, 'h15, 0);                // R1 signed byte
    run_op(0, 0, 0, 'h17, 0);                // R1 unsigned byte
    run_op(0, 1, 1, 'h1A, 0);                // R1 signed half
    run_op(0, 1, 0, 'h19, 0);                // R1 half inside word
    run_op(1, 2, 0, 'h20, 32'h8899AABB);     // R3 aligned store
    run_op(1, 0, 0, 'h26, 32'h000000F3);     // R3 byte lane 2
    run_op(1, 1, 0, 'h29, 32'h00008123);     // R3 half lane 1
    run_op(0, 2, 0, 'h20, 0);
    run_op(0, 2, 0, 'h24, 0);
    run_op(0, 2, 0, 'h28, 0);
    run_op(0, 2, 0, 'h31, 0);                // R6 R7 split offsets
    run_op(0, 2, 1, 'h32, 0);
    run_op(0, 2, 0, 'h33, 0);
    run_op(0, 1, 1, 'h37, 0);                // R6 half at offset 3
    run_op(1, 2, 0, 'h43, 32'hCAFEF00D);     // R6 split store
    run_op(1, 1, 0, 'h4B, 32'h00001234);
    run_op(0, 2, 0, 'h40, 0);
    run_op(0, 2, 0, 'h44, 0);
    run_op(0, 2, 0, 'h48, 0);
    run_op(0, 2, 0, 'h4C, 0);
    run_op(0, 2, 0, 'hA0, 0);                // R10 single error
    run_op(0, 2, 0, 'hA1, 0);                // R8 abandoned second part
    run_op(0, 2, 0, 'h50, 0);                // R9 waits behind it
    run_op(0, 2, 0, 'h9E, 0);                // R10 second-part error
    run_op(1, 2, 0, 'hA2, 32'h01020304);     // R8 split store, first part faults
    run_op(0, 2, 0, 'hA4, 0);
    run_op(0, 2, 0, 'hFE, 0);                // R6 wrap past model end
    for (int i = 0; i < 80; i++) begin
      int sz;
      sz = int'($urandom_range(0, 2));
      run_op($urandom_range(0, 1) == 1, sz, $urandom_range(0, 1) == 1,
             int'($urandom_range(0, 255)), $urandom);
    end
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0 && bus_q.size() == 0,
          $sformatf("R8 leftover items: results %0d bus %0d act, 0 0 exp", exp_q.size(), bus_q.size()));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule